// File: doc/BRIEF.md
# Phase-Offset Pulse-Width Modulator

This block is a single-channel pulse-width modulator controlled through a small word-addressed register port. Software programs three counts, all in clock cycles. The period count sets the length of one cycle of the waveform. The offset count sets how far into each period the pulse starts. The duty count sets how long the pulse stays high. Values written while the channel runs are held in the programming registers and reach the running counter only when the current period ends, so no period is ever built from a mix of old and new settings.

The channel runs only while both bits of its two-bit enable field are set. Clearing either bit stops the waveform on the next clock edge, even in the middle of a period, and the pin keeps the level it had at that moment. In one-shot mode the channel produces a programmed number of periods and then stops on its own. It also sets a sticky completion flag, and a mask bit decides whether that flag drives the interrupt output.

Top module: `phased_pwm`

## Requirements
- R1: Period (address 0), duty (address 1) and offset (address 2) are 32-bit registers. Each reads back exactly the value last written, and all three reset to 0.
- R2: A duty write made while the channel runs has no effect on the period in progress. The new duty applies from the first cycle of the next period.
- R3: A period or offset write made while the channel runs applies only from the start of the next period. The period in progress keeps its old length and old offset.
- R4: While running, the cycle counter steps 0, 1, ... up to period−1 and then wraps. A period of 0 or 1 gives a one-cycle period. The output is 1 when offset ≤ count < offset+duty and 0 otherwise. A duty of 0 therefore gives a constant 0, and a pulse with offset+duty ≥ period is cut off at the wrap.
- R5: The enable register (address 3) holds bits [1:0]. The channel runs only when both bits are 1. A read returns those two bits, with every higher bit reading 0.
- R6: When both enable bits become set, the counter starts at count 0 on the clock edge after the write lands, using the register values present at that edge.
- R7: When either enable bit is cleared, the output stops following the waveform right after the edge on which the write lands. The output then holds its last level until the channel is started again.
- R8: When mode bit 0 (address 4) is 1 at start, the channel runs N periods, where N is the repeat register (address 5) and N=0 counts as 1. It then stops and holds the level of the last cycle. A new run needs the enable bits to be cleared and set again.
- R9: Status bit 0 (address 6) is set when a one-shot run completes and stays set until software writes a 1 to that bit. Writing 0 to it has no effect.
- R10: The interrupt output equals status bit 0 AND mask bit 0 (address 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data for rd_addr |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench writes duty, period and offset at random points in running periods. A design that applied these values at once would produce a period that mixes two settings, such as a truncated period or a pulse at the wrong phase. It disables the channel while the output is high and checks that the level is held. A design that drove the pin low or let the period finish would fail this check. It also covers duty 0, offset+duty past the period, and periods of 0 and 1, where a counter that mishandles the wrap compare would overrun or stick. Finally, it runs one-shot sequences with repeat counts of 0 and several periods, and checks the flag, the masking and the write-1 clear. An off-by-one error in the repeat counter would show up there as one period too many or too few.

// File: rtl/phased_pwm_pkg.sv
package phased_pwm_pkg;
  typedef logic [2:0] reg_addr_t;
  localparam reg_addr_t ADDR_PERIOD = 3'd0;
  localparam reg_addr_t ADDR_DUTY   = 3'd1;
  localparam reg_addr_t ADDR_OFFSET = 3'd2;
  localparam reg_addr_t ADDR_ENABLE = 3'd3;
  localparam reg_addr_t ADDR_MODE   = 3'd4;
  localparam reg_addr_t ADDR_REPEAT = 3'd5;
  localparam reg_addr_t ADDR_STATUS = 3'd6;
  localparam reg_addr_t ADDR_MASK   = 3'd7;
endpackage

// File: rtl/phased_pwm_regs.sv
module phased_pwm_regs
  import phased_pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_addr_t     wr_addr,
  input  logic [DW-1:0] wr_data,
  input  reg_addr_t     rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          done_evt,
  output logic [DW-1:0] per_q,
  output logic [DW-1:0] duty_q,
  output logic [DW-1:0] off_q,
  output logic [DW-1:0] rep_q,
  output logic          en_both,
  output logic          mode_q,
  output logic          irq
);
  logic [DW-1:0] per_d, duty_d, off_d, rep_d;
  logic [1:0]    en_q, en_d;
  logic          mode_d, mask_q, mask_d, flag_q, flag_d;

  always_comb begin
    per_d  = per_q;
    duty_d = duty_q;
    off_d  = off_q;
    rep_d  = rep_q;
    en_d   = en_q;
    mode_d = mode_q;
    mask_d = mask_q;
    flag_d = flag_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_PERIOD: per_d  = wr_data;
        ADDR_DUTY:   duty_d = wr_data;
        ADDR_OFFSET: off_d  = wr_data;
        ADDR_ENABLE: en_d   = wr_data[1:0];
        ADDR_MODE:   mode_d = wr_data[0];
        ADDR_REPEAT: rep_d  = wr_data;
        ADDR_STATUS: if (wr_data[0]) flag_d = 1'b0;
        default:     mask_d = wr_data[0];
      endcase
    end
    if (done_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      off_q  <= '0;
      rep_q  <= '0;
      en_q   <= '0;
      mode_q <= 1'b0;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      per_q  <= per_d;
      duty_q <= duty_d;
      off_q  <= off_d;
      rep_q  <= rep_d;
      en_q   <= en_d;
      mode_q <= mode_d;
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign en_both = &en_q;
  assign irq     = flag_q & mask_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_PERIOD: rd_data = per_q;
      ADDR_DUTY:   rd_data = duty_q;
      ADDR_OFFSET: rd_data = off_q;
      ADDR_ENABLE: rd_data[1:0] = en_q;
      ADDR_MODE:   rd_data[0] = mode_q;
      ADDR_REPEAT: rd_data = rep_q;
      ADDR_STATUS: rd_data[0] = flag_q;
      default:     rd_data[0] = mask_q;
    endcase
  end

  // R9: a completion always leaves the flag set
  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> flag_q);
  // R9: write-1 clears the flag when no completion coincides
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_STATUS && wr_data[0] && !done_evt) |=> !flag_q);
endmodule

// File: rtl/phased_pwm_counter.sv
module phased_pwm_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_both,
  input  logic [DW-1:0] per_in,
  input  logic [DW-1:0] duty_in,
  input  logic [DW-1:0] off_in,
  input  logic [DW-1:0] rep_in,
  input  logic          mode_in,
  output logic          run,
  output logic          win,
  output logic          done_evt
);
  localparam int CW = DW + 1;

  logic          active_q, active_d, done_q, done_d, mode_a, mode_ad;
  logic [DW-1:0] cnt_q, cnt_d, per_a, per_ad, duty_a, duty_ad;
  logic [DW-1:0] off_a, off_ad, rep_a, rep_ad, pcnt_q, pcnt_d, rep_eff;
  logic          wrap, last, start;

  assign wrap    = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, per_a};
  assign rep_eff = (rep_a == '0) ? DW'(1) : rep_a;
  assign last    = mode_a && (({1'b0, pcnt_q} + CW'(1)) >= {1'b0, rep_eff});
  assign start   = !active_q && en_both && !done_q;

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    cnt_d    = cnt_q;
    pcnt_d   = pcnt_q;
    per_ad   = per_a;
    duty_ad  = duty_a;
    off_ad   = off_a;
    rep_ad   = rep_a;
    mode_ad  = mode_a;
    done_evt = 1'b0;
    if (!en_both) begin
      active_d = 1'b0;
      done_d   = 1'b0;
    end else if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
      pcnt_d   = '0;
      per_ad   = per_in;
      duty_ad  = duty_in;
      off_ad   = off_in;
      rep_ad   = rep_in;
      mode_ad  = mode_in;
    end else if (active_q) begin
      if (wrap) begin
        cnt_d   = '0;
        pcnt_d  = pcnt_q + DW'(1);
        per_ad  = per_in;
        duty_ad = duty_in;
        off_ad  = off_in;
        if (last) begin
          active_d = 1'b0;
          done_d   = 1'b1;
          done_evt = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      pcnt_q   <= '0;
      per_a    <= '0;
      duty_a   <= '0;
      off_a    <= '0;
      rep_a    <= '0;
      mode_a   <= 1'b0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      cnt_q    <= cnt_d;
      pcnt_q   <= pcnt_d;
      per_a    <= per_ad;
      duty_a   <= duty_ad;
      off_a    <= off_ad;
      rep_a    <= rep_ad;
      mode_a   <= mode_ad;
    end
  end

  assign run = active_q && en_both;
  assign win = ({1'b0, cnt_q} >= {1'b0, off_a}) &&
               ({1'b0, cnt_q} < ({1'b0, off_a} + {1'b0, duty_a}));

  // R4: the count never reaches the active period
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (({1'b0, cnt_q} < {1'b0, per_a}) || cnt_q == '0));
  // R2 / R3: active values change only at a wrap or a start
  a_r2_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$past(wrap)) |->
      ($stable(duty_a) && $stable(per_a) && $stable(off_a)));
  // R6: every run begins at count zero
  a_r6_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> cnt_q == '0);
  // R8: the last one-shot period stops the channel
  a_r8_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!active_q && done_q));
endmodule

// File: rtl/phased_pwm_output.sv
module phased_pwm_output (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic win,
  output logic pwm_out
);
  logic hold_q, hold_d;

  always_comb begin
    pwm_out = run ? win : hold_q;
    hold_d  = pwm_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  // R7: while stopped the pin does not move
  a_r7_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pwm_out == $past(pwm_out));
endmodule

// File: rtl/phased_pwm.sv
module phased_pwm
  import phased_pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          pwm_out,
  output logic          irq
);
  logic [1:0]    rst_sync_q;
  logic          rst_i;
  logic [DW-1:0] per_q, duty_q, off_q, rep_q;
  logic          en_both, mode_q, done_evt, run, win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  phased_pwm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .done_evt(done_evt), .per_q(per_q), .duty_q(duty_q), .off_q(off_q),
    .rep_q(rep_q), .en_both(en_both), .mode_q(mode_q), .irq(irq)
  );

  phased_pwm_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_i), .en_both(en_both), .per_in(per_q),
    .duty_in(duty_q), .off_in(off_q), .rep_in(rep_q), .mode_in(mode_q),
    .run(run), .win(win), .done_evt(done_evt)
  );

  phased_pwm_output u_out (
    .clk(clk), .rst_n(rst_i), .run(run), .win(win), .pwm_out(pwm_out)
  );
endmodule

// File: tb/phased_pwm_test.sv
`timescale 1ns/1ps
module phased_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        pwm_out, irq;

  phased_pwm uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  string tag = "R4";

  // programmed values, active values and run state of the reference
  longint pP, pD, pO, pRep, aP, aD, aO, aRep, ph, pc;
  bit pMode, pMask, aMode, m_on, m_start, m_done, m_flag, hold_exp, exp_out;
  logic [1:0] pEn;

  function automatic bit win_f(longint c, longint d, longint o);
    return (c >= o) && (c < o + d);
  endfunction

  task automatic check(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // one clock edge with an optional write, then check pin and interrupt
  task automatic cyc(bit we, logic [2:0] a, logic [31:0] d);
    longint oP = pP, oD = pD, oO = pO, oRep = pRep;
    bit oMode = pMode, done_now = 1'b0;
    wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (m_on) begin
      if (ph + 1 >= aP) begin
        ph = 0; pc++;
        aP = oP; aD = oD; aO = oO;
        if (aMode && pc >= ((aRep == 0) ? 1 : aRep)) begin
          m_on = 1'b0; m_done = 1'b1; done_now = 1'b1;
        end
      end else ph++;
    end else if (m_start) begin
      m_on = 1'b1; m_start = 1'b0; ph = 0; pc = 0;
      aP = oP; aD = oD; aO = oO; aRep = oRep; aMode = oMode;
    end
    if (we) begin
      case (a)
        3'd0: pP = d;
        3'd1: pD = d;
        3'd2: pO = d;
        3'd3: begin
          pEn = d[1:0];
          if (pEn != 2'b11) begin m_on = 1'b0; m_start = 1'b0; m_done = 1'b0; end
          else if (!m_on && !m_done) m_start = 1'b1;
        end
        3'd4: pMode = d[0];
        3'd5: pRep = d;
        3'd6: if (d[0]) m_flag = 1'b0;
        default: pMask = d[0];
      endcase
    end
    if (done_now) m_flag = 1'b1;
    exp_out = m_on ? win_f(ph, aD, aO) : hold_exp;
    hold_exp = exp_out;
    check(tag, pwm_out, exp_out);
    check("R10", irq, m_flag & pMask);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0);
  endtask

  task automatic chk_rd(logic [2:0] a, longint expv, string req);
    rd_addr = a;
    #1;
    check(req, rd_data, expv);
  endtask

  task automatic setup(longint p, longint d, longint o);
    cyc(1'b1, 3'd0, p[31:0]);
    cyc(1'b1, 3'd1, d[31:0]);
    cyc(1'b1, 3'd2, o[31:0]);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251028));
    pP = 0; pD = 0; pO = 0; pRep = 0; aP = 0; aD = 0; aO = 0; aRep = 0;
    ph = 0; pc = 0; pMode = 0; pMask = 0; aMode = 0; pEn = 0;
    m_on = 0; m_start = 0; m_done = 0; m_flag = 0; hold_exp = 0; exp_out = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check("R1", pwm_out, 0);
    check("R10", irq, 0);
    for (int a = 0; a < 8; a++) chk_rd(a[2:0], 0, "R1");

    // R1 read-back of full-width values
    tag = "R1";
    setup(64'hDEADBEEF, 64'h12345678, 64'h0F0F0F0F);
    chk_rd(3'd0, 64'hDEADBEEF, "R1");
    chk_rd(3'd1, 64'h12345678, "R1");
    chk_rd(3'd2, 64'h0F0F0F0F, "R1");

    // R5: a single enable bit does not run; read-back masks upper bits
    tag = "R5";
    setup(8, 3, 0);
    cyc(1'b1, 3'd3, 32'hFFFF_FFFE);
    chk_rd(3'd3, 2, "R5");
    idle(12);
    cyc(1'b1, 3'd3, 32'h0000_0001);
    chk_rd(3'd3, 1, "R5");
    idle(12);

    // R6 / R4: start and continuous waveform
    tag = "R6";
    setup(8, 3, 2);
    cyc(1'b1, 3'd3, 32'h3);
    idle(3);
    tag = "R4";
    idle(24);

    // R2: duty change mid-period
    tag = "R2";
    idle(3);
    cyc(1'b1, 3'd1, 32'd6);
    idle(20);
    // R3: period and offset change mid-period
    tag = "R3";
    idle(2);
    cyc(1'b1, 3'd0, 32'd5);
    cyc(1'b1, 3'd2, 32'd1);
    idle(20);

    // R4 corners: duty 0, pulse past the wrap, period 1 and period 0
    tag = "R4";
    cyc(1'b1, 3'd1, 32'd0);
    idle(15);
    setup(6, 4, 4);
    idle(20);
    setup(1, 1, 0);
    idle(10);
    cyc(1'b1, 3'd0, 32'd0);
    idle(10);

    // R7: disable while high, hold, re-enable, disable while low
    tag = "R7";
    setup(10, 6, 1);
    idle(12);
    while (!exp_out) cyc(1'b0, 3'd0, 32'd0);
    cyc(1'b1, 3'd3, 32'h2);
    check("R7", pwm_out, 1);
    idle(15);
    cyc(1'b1, 3'd3, 32'h3);
    idle(12);
    while (exp_out) cyc(1'b0, 3'd0, 32'd0);
    cyc(1'b1, 3'd3, 32'h0);
    check("R7", pwm_out, 0);
    idle(15);

    // R8 / R9 / R10: one-shot with three periods, last cycle high
    tag = "R8";
    setup(4, 2, 2);
    cyc(1'b1, 3'd4, 32'h1);
    cyc(1'b1, 3'd5, 32'd3);
    cyc(1'b1, 3'd3, 32'h3);
    idle(20);
    check("R8", pwm_out, 1);
    chk_rd(3'd6, 1, "R9");
    cyc(1'b1, 3'd6, 32'h0);
    chk_rd(3'd6, 1, "R9");
    cyc(1'b1, 3'd7, 32'h1);
    check("R10", irq, 1);
    cyc(1'b1, 3'd6, 32'h1);
    chk_rd(3'd6, 0, "R9");
    check("R10", irq, 0);
    // repeat of 0 runs one period
    cyc(1'b1, 3'd5, 32'd0);
    cyc(1'b1, 3'd3, 32'h0);
    setup(5, 2, 0);
    cyc(1'b1, 3'd3, 32'h3);
    idle(15);
    chk_rd(3'd6, 1, "R8");
    cyc(1'b1, 3'd6, 32'h1);
    cyc(1'b1, 3'd3, 32'h0);
    cyc(1'b1, 3'd4, 32'h0);

    // random programming, mid-run writes and disables
    for (int r = 0; r < 40; r++) begin
      int p = $urandom_range(12, 1);
      tag = "R4";
      setup(p, $urandom_range(p, 0), $urandom_range(p, 0));
      cyc(1'b1, 3'd4, {31'd0, 1'($urandom_range(1, 0))});
      cyc(1'b1, 3'd5, $urandom_range(4, 0));
      cyc(1'b1, 3'd3, 32'h3);
      for (int k = 0; k < 30; k++) begin
        int sel = $urandom_range(19, 0);
        tag = (sel < 2) ? "R2" : (sel < 4) ? "R3" : "R4";
        if (sel == 0)      cyc(1'b1, 3'd1, $urandom_range(12, 0));
        else if (sel == 2) cyc(1'b1, 3'd0, $urandom_range(12, 0));
        else if (sel == 3) cyc(1'b1, 3'd2, $urandom_range(6, 0));
        else               cyc(1'b0, 3'd0, 32'd0);
      end
      chk_rd(3'd6, m_flag, "R9");
      tag = "R7";
      cyc(1'b1, 3'd3, 32'h0);
      idle(3);
      cyc(1'b1, 3'd6, 32'h1);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule